// File: doc/BRIEF.md
# Execute-Stage Arithmetic and Logic Datapath

This block is the combinational execute stage of a 32-bit, five-stage load/store processor. Fields of the per-instruction control word steer it. The stage picks two operands. Operand A is either the next program-counter value or register read port 1. Operand B is either an extended immediate or register read port 2. From these operands the stage forms five candidate results: a sum or difference, a bitwise logic function, a shifted value, a set-on-compare flag and a constant zero for the reserved codes. An output select then chooses one candidate as the stage result.

The logic function is given as a four-bit truth table over the bit pairs of the two operands, not as an operation name. The shift amount is taken from the low bits of operand B. Comparisons are signed. They reuse the shared adder in subtract mode and combine its sign, overflow and zero signals. Multiply and divide units are outside this block. Their output-select codes produce zero here.

Top module: `exs_execute_stage`

## Requirements
- R1: When `imm_short` is 1, the immediate is `imm_field[15:0]`. When `imm_sign` is also 0, bits 31:16 of the extended immediate are zero.
- R2: When `imm_short` is 1 and `imm_sign` is 1, the 16-bit immediate is sign-extended from bit 15. When `imm_short` is 0, the immediate is `imm_field[25:0]`, always sign-extended from bit 25.
- R3: Operand A is `next_pc` when `a_from_reg` is 0 and `reg_a` when it is 1. Operand B is the extended immediate when `b_from_imm` is 1 and `reg_b` when it is 0.
- R4: With `out_code`=001, the result is A+B modulo 2^32 when `sub_mode` is 0 and A-B modulo 2^32 when `sub_mode` is 1.
- R5: With `out_code`=010, each result bit i equals `logic_code[{A[i],B[i]}]`. So bit 3 enables A&B, bit 2 enables A&~B, bit 1 enables ~A&B and bit 0 enables ~A&~B. As examples, 1000 gives AND, 1110 gives OR, 0110 gives XOR, 0001 gives NOR, 0111 gives NAND and 1001 gives XNOR.
- R6: With `out_code`=011, `shift_code` 00 shifts A left and `shift_code` 01 shifts A right logically, both by B[4:0] with zero fill. `shift_code` 10 and 11 give zero.
- R7: With `out_code`=000 and `sub_mode`=1, the result is 1 or 0 for the signed test of A against B. `cmp_code` selects the test: 000 is <=, 001 is <, 010 is >, 011 is >=, 100 is == and 101 is !=. Codes 110 and 111 give 0. The test is correct at the limits of the 32-bit range.
- R8: `out_code` 000 selects compare, 001 the adder, 010 logic and 011 the shifter. Codes 100 to 111, which include the reserved multiply and divide codes, give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_field | input | 26 | Immediate bits 25:0 of the instruction |
| imm_short | input | 1 | 1 selects the 16-bit immediate, 0 selects the 26-bit immediate |
| imm_sign | input | 1 | Signedness of the 16-bit immediate (1 = signed) |
| a_from_reg | input | 1 | Operand A select: 0 = next_pc, 1 = reg_a |
| b_from_imm | input | 1 | Operand B select: 1 = immediate, 0 = reg_b |
| reg_a | input | 32 | Register read port 1 value |
| reg_b | input | 32 | Register read port 2 value |
| next_pc | input | 32 | Next program-counter value |
| sub_mode | input | 1 | Adder mode: 0 = add, 1 = subtract |
| logic_code | input | 4 | Truth-table select of the logic unit |
| shift_code | input | 2 | Shift operation select |
| cmp_code | input | 3 | Compare condition select |
| out_code | input | 3 | Stage result select |
| result | output | 32 | Execute-stage result |

## Verification
The assertions assume that every input is a settled two-state value whenever the combinational logic is evaluated. The compare-related checks also assume that a compare is requested only with `sub_mode` at 1, which is how the control word encodes every set-on-compare instruction. The random stimulus follows the same rule: it forces `sub_mode` to 1 whenever `out_code` selects the compare path. It changes inputs only at a clock edge and samples the result half a period later. Operands are drawn partly from a pool of boundary values: zero, one, all-ones, the most negative and most positive values, and shift amount 31.

// File: rtl/exs_pkg.sv
package exs_pkg;

  typedef enum logic [2:0] {
    OUT_CMP   = 3'b000,
    OUT_ADD   = 3'b001,
    OUT_LOGIC = 3'b010,
    OUT_SHIFT = 3'b011,
    OUT_MUL   = 3'b100,
    OUT_DIV   = 3'b101
  } out_sel_e;

  typedef enum logic [2:0] {
    CMP_LE = 3'b000,
    CMP_LT = 3'b001,
    CMP_GT = 3'b010,
    CMP_GE = 3'b011,
    CMP_EQ = 3'b100,
    CMP_NE = 3'b101
  } cmp_sel_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01
  } shift_sel_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
  } add_flags_t;

  // Extend a 16-bit (short=1) or 26-bit (short=0) immediate to xlen bits.
  function automatic logic [63:0] extend_imm(input logic [25:0] field,
                                             input logic short_sel,
                                             input logic signed_sel);
    logic [63:0] v;
    if (short_sel) begin
      v = signed_sel ? {{48{field[15]}}, field[15:0]} : {48'd0, field[15:0]};
    end else begin
      v = {{38{field[25]}}, field[25:0]};
    end
    return v;
  endfunction

  // Signed ordering from the flags of a - b.
  function automatic logic cmp_eval(input logic [2:0] code, input add_flags_t f);
    logic lt;
    logic res;
    lt = f.neg ^ f.ovf;
    case (code)
      CMP_LE:  res = lt | f.zero;
      CMP_LT:  res = lt;
      CMP_GT:  res = ~lt & ~f.zero;
      CMP_GE:  res = ~lt;
      CMP_EQ:  res = f.zero;
      CMP_NE:  res = ~f.zero;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/exs_operand_mux.sv
module exs_operand_mux
  import exs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [25:0]     imm_field,
  input  logic            imm_short,
  input  logic            imm_sign,
  input  logic            a_from_reg,
  input  logic            b_from_imm,
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] reg_b,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] imm_ext,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b
);

  logic [63:0] imm_wide;

  always_comb begin
    imm_wide = extend_imm(imm_field, imm_short, imm_sign);
    imm_ext  = imm_wide[XLEN-1:0];
    op_a     = a_from_reg ? reg_a : next_pc;
    op_b     = b_from_imm ? imm_ext : reg_b;
  end

  if (XLEN < 64) begin : g_unused_hi
    logic unused_hi;
    assign unused_hi = ^imm_wide[63:XLEN];
  end

  always_comb begin
    if (imm_short && !imm_sign)
      AST_IMM_ZERO_UPPER: assert (imm_ext[XLEN-1:16] == '0); // R1
    if (imm_short && imm_sign)
      AST_IMM_SIGN_COPY: assert (imm_ext[XLEN-1:16] == {(XLEN-16){imm_field[15]}}); // R2
    if (!imm_short)
      AST_IMM_LONG_SIGN: assert (imm_ext[XLEN-1:25] == {(XLEN-25){imm_field[25]}}); // R2
  end

endmodule

// File: rtl/exs_addsub.sv
module exs_addsub
  import exs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            sub_mode,
  output logic [XLEN-1:0] sum,
  output add_flags_t      flags
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;

  always_comb begin
    b_eff      = op_b ^ {XLEN{sub_mode}};
    sum        = op_a + b_eff + {{(XLEN-1){1'b0}}, sub_mode};
    flags.neg  = sum[MSB];
    flags.ovf  = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
    flags.zero = (sum == '0);
  end

  always_comb begin
    if (sub_mode)
      AST_SUB_INVERSE: assert (XLEN'(sum + op_b) == op_a); // R4
    if (sub_mode)
      AST_SUB_ZERO_EQ: assert (flags.zero == (op_a == op_b)); // R7
    if (sub_mode)
      AST_SUB_SIGNED_LT: assert ((flags.neg ^ flags.ovf) == ($signed(op_a) < $signed(op_b))); // R7
  end

endmodule

// File: rtl/exs_logic_unit.sv
module exs_logic_unit #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [3:0]      logic_code,
  output logic [XLEN-1:0] logic_out
);

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    logic t_ab, t_anb, t_nab, t_nanb;
    assign t_ab   = logic_code[3] &  op_a[i] &  op_b[i];
    assign t_anb  = logic_code[2] &  op_a[i] & ~op_b[i];
    assign t_nab  = logic_code[1] & ~op_a[i] &  op_b[i];
    assign t_nanb = logic_code[0] & ~op_a[i] & ~op_b[i];
    assign logic_out[i] = t_ab | t_anb | t_nab | t_nanb;
  end

  always_comb begin
    if (logic_code == 4'b1000)
      AST_LOGIC_AND: assert (logic_out == (op_a & op_b)); // R5
    if (logic_code == 4'b0110)
      AST_LOGIC_XOR: assert (logic_out == (op_a ^ op_b)); // R5
  end

endmodule

// File: rtl/exs_shifter.sv
module exs_shifter
  import exs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [1:0]      shift_code,
  output logic [XLEN-1:0] shift_out
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] amount;

  always_comb begin
    amount = op_b[SHW-1:0];
    case (shift_code)
      SH_LEFT:  shift_out = op_a << amount;
      SH_RIGHT: shift_out = op_a >> amount;
      default:  shift_out = '0;
    endcase
  end

  always_comb begin
    if (shift_code == SH_LEFT)
      AST_SHL_ZERO_FILL: assert ((shift_out & ~({XLEN{1'b1}} << amount)) == '0); // R6
    if (shift_code == SH_RIGHT)
      AST_SHR_ZERO_FILL: assert ((shift_out & ~({XLEN{1'b1}} >> amount)) == '0); // R6
  end

endmodule

// File: rtl/exs_execute_stage.sv
module exs_execute_stage
  import exs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [25:0]     imm_field,
  input  logic            imm_short,
  input  logic            imm_sign,
  input  logic            a_from_reg,
  input  logic            b_from_imm,
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] reg_b,
  input  logic [XLEN-1:0] next_pc,
  input  logic            sub_mode,
  input  logic [3:0]      logic_code,
  input  logic [1:0]      shift_code,
  input  logic [2:0]      cmp_code,
  input  logic [2:0]      out_code,
  output logic [XLEN-1:0] result
);

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic [XLEN-1:0] sum;
  add_flags_t      flags;
  logic [XLEN-1:0] logic_out;
  logic [XLEN-1:0] shift_out;
  logic            cmp_bit;

  exs_operand_mux #(.XLEN(XLEN)) u_opmux (
    .imm_field  (imm_field),
    .imm_short  (imm_short),
    .imm_sign   (imm_sign),
    .a_from_reg (a_from_reg),
    .b_from_imm (b_from_imm),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .next_pc    (next_pc),
    .imm_ext    (imm_ext),
    .op_a       (op_a),
    .op_b       (op_b)
  );

  exs_addsub #(.XLEN(XLEN)) u_addsub (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_mode (sub_mode),
    .sum      (sum),
    .flags    (flags)
  );

  exs_logic_unit #(.XLEN(XLEN)) u_logic (
    .op_a       (op_a),
    .op_b       (op_b),
    .logic_code (logic_code),
    .logic_out  (logic_out)
  );

  exs_shifter #(.XLEN(XLEN)) u_shift (
    .op_a       (op_a),
    .op_b       (op_b),
    .shift_code (shift_code),
    .shift_out  (shift_out)
  );

  assign cmp_bit = cmp_eval(cmp_code, flags);

  always_comb begin
    case (out_code)
      OUT_CMP:   result = {{(XLEN-1){1'b0}}, cmp_bit};
      OUT_ADD:   result = sum;
      OUT_LOGIC: result = logic_out;
      OUT_SHIFT: result = shift_out;
      default:   result = '0;
    endcase
  end

  logic unused_imm;
  assign unused_imm = ^imm_ext;

  always_comb begin
    if (out_code[2])
      AST_RESERVED_ZERO: assert (result == '0); // R8
    if (out_code == OUT_CMP)
      AST_CMP_BOOLEAN: assert (result[XLEN-1:1] == '0); // R7
    if (a_from_reg == 1'b0)
      AST_OPA_FROM_PC: assert (op_a == next_pc); // R3
  end

endmodule

// File: tb/exs_execute_stage_test.sv
`timescale 1ns/1ps
module exs_execute_stage_test;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic [25:0] imm_field;
  logic        imm_short, imm_sign, a_from_reg, b_from_imm, sub_mode;
  logic [31:0] reg_a, reg_b, next_pc, result;
  logic [3:0]  logic_code;
  logic [1:0]  shift_code;
  logic [2:0]  cmp_code, out_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  exs_execute_stage uut (
    .imm_field(imm_field), .imm_short(imm_short), .imm_sign(imm_sign),
    .a_from_reg(a_from_reg), .b_from_imm(b_from_imm),
    .reg_a(reg_a), .reg_b(reg_b), .next_pc(next_pc),
    .sub_mode(sub_mode), .logic_code(logic_code), .shift_code(shift_code),
    .cmp_code(cmp_code), .out_code(out_code), .result(result)
  );

  function automatic logic [31:0] ref_imm();
    if (imm_short) return imm_sign ? 32'($signed(imm_field[15:0])) : {16'h0, imm_field[15:0]};
    return 32'($signed(imm_field));
  endfunction

  function automatic logic [31:0] ref_result();
    logic [31:0] a, b, r;
    logic signed [31:0] sa, sb;
    a = a_from_reg ? reg_a : next_pc;
    b = b_from_imm ? ref_imm() : reg_b;
    sa = a; sb = b;
    r = 32'h0;
    case (out_code)
      3'd0: case (cmp_code)
              3'd0: r = 32'(sa <= sb);
              3'd1: r = 32'(sa <  sb);
              3'd2: r = 32'(sa >  sb);
              3'd3: r = 32'(sa >= sb);
              3'd4: r = 32'(a == b);
              3'd5: r = 32'(a != b);
              default: r = 32'h0;
            endcase
      3'd1: r = sub_mode ? a - b : a + b;
      3'd2: for (int i = 0; i < 32; i++) r[i] = logic_code[{a[i], b[i]}];
      3'd3: begin
              if (shift_code == 2'b00)      for (int k = 0; k < 32; k++) r[k] = (k >= b[4:0]) ? a[k - b[4:0]] : 1'b0;
              else if (shift_code == 2'b01) for (int k = 0; k < 32; k++) r[k] = (k + b[4:0] < 32) ? a[k + b[4:0]] : 1'b0;
            end
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic string tag_of();
    case (out_code)
      3'd0: return "R7";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s: result=%h expected=%h (out=%b cmp=%b lg=%b sh=%b sub=%b)",
               req, result, exp, out_code, cmp_code, logic_code, shift_code, sub_mode);
    end
  endtask

  task automatic quiet();
    imm_field = '0; imm_short = 1'b1; imm_sign = 1'b0; a_from_reg = 1'b1; b_from_imm = 1'b0;
    reg_a = '0; reg_b = '0; next_pc = '0; sub_mode = 1'b0;
    logic_code = '0; shift_code = '0; cmp_code = '0; out_code = 3'd1;
  endtask

  // Apply at the rising edge, sample at the falling edge.
  task automatic step(input string req);
    @(negedge clk);
    check(req, ref_result());
    @(posedge clk);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] pool [7];
    pool = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'd31, 32'hFFFF_FFFE};
    if ($urandom % 4 == 0) return pool[$urandom % 7];
    return $urandom;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    quiet();
    @(posedge clk);
    @(negedge clk);
    check("reset-idle R4", 32'h0);
    @(posedge clk);

    // R1: unsigned 16-bit immediate, passed through the adder.
    quiet(); b_from_imm = 1'b1; imm_field = 26'h3FF_8001; step("R1");
    // R2: signed 16-bit and 26-bit immediates
    imm_sign = 1'b1; step("R2");
    imm_short = 1'b0; imm_field = 26'h200_0004; step("R2");
    imm_field = 26'h0FF_FFFF; step("R2");
    // R3: operand A from next_pc
    quiet(); a_from_reg = 1'b0; next_pc = 32'h0000_1000; reg_a = 32'hDEAD_0000;
    reg_b = 32'h4; step("R3");
    // R7 range limits
    quiet(); out_code = 3'd0; sub_mode = 1'b1; cmp_code = 3'd1;
    reg_a = 32'h8000_0000; reg_b = 32'h1; step("R7");
    cmp_code = 3'd2; reg_a = 32'h7FFF_FFFF; reg_b = 32'hFFFF_FFFF; step("R7");
    cmp_code = 3'd0; reg_a = 32'h5; reg_b = 32'h5; step("R7");
    cmp_code = 3'd6; step("R7");
    // R6 shift by 31 and unused code
    quiet(); out_code = 3'd3; reg_a = 32'hFFFF_FFFF; reg_b = 32'd31; step("R6");
    shift_code = 2'b01; step("R6");
    shift_code = 2'b10; step("R6");
    // R5 named logic codes
    quiet(); out_code = 3'd2; reg_a = 32'hF0F0_1234; reg_b = 32'hFF00_8765;
    foreach (logic_code[i]) ;
    logic_code = 4'b1000; step("R5");
    logic_code = 4'b1110; step("R5");
    logic_code = 4'b0001; step("R5");
    logic_code = 4'b1001; step("R5");
    // R8 reserved outputs
    for (int c = 4; c < 8; c++) begin
      out_code = 3'(c); step("R8");
    end

    for (int n = 0; n < 600; n++) begin
      imm_field = 26'($urandom); imm_short = 1'($urandom); imm_sign = 1'($urandom);
      a_from_reg = 1'($urandom); b_from_imm = 1'($urandom);
      reg_a = pick(); reg_b = pick(); next_pc = pick();
      out_code = 3'($urandom % 8);
      sub_mode = (out_code == 3'd0) ? 1'b1 : 1'($urandom);
      logic_code = 4'($urandom); shift_code = 2'($urandom);
      cmp_code = 3'($urandom % 8);
      step({tag_of(), " R3"});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: result=%h expected=completion", result);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule